// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors kept in system memory and feeds a frame sender one buffer at a time. Each descriptor takes four 32-bit words at consecutive byte offsets 0, 4, 8 and 12: a status word holding the ownership flag, a control word holding the segment flags and the byte count, the buffer address, and a link word. The engine reads all four words, offers the buffer to the sender through a request/done handshake, and then writes the status word back. That write gives the descriptor back to the host.

Software places the ring base in a register and raises the transmit enable. The engine starts at the base and moves through the ring until it reads a descriptor it does not own. At that point it suspends. A poll-demand strobe then makes it read the same descriptor again. The next descriptor is found in one of three ways: by stepping forward 16 bytes, by jumping back to the base when the end-of-ring flag is set, or by following the link word when the chain flag is set.

Top module: `txring_engine`

## Requirements
- R1: While reset is held and after it is released with transmit disabled, mem_req, snd_req, tx_irq and tx_suspended are all 0.
- R2: When transmit is enabled from the idle state, the first memory read goes to csr_ring_base.
- R3: If status word bit 31 (ownership) reads 0, no send is requested and no write is made. tx_suspended goes high and stays high with no memory or send activity, even if the host sets ownership in the meantime, until a poll demand arrives.
- R4: A poll demand while suspended re-reads the status word at the same descriptor address and, if ownership is now set, processes that descriptor.
- R5: snd_req shows the buffer address from word 2, the byte count from control bits 10:0, the first-segment flag from control bit 29 and the last-segment flag from control bit 30. These stay stable until snd_done, and no memory access happens while snd_req is high.
- R6: Once per descriptor, after snd_done, the engine writes the status word with bit 31 cleared, bit 15 equal to snd_err sampled with snd_done, and every other bit 0. This is the only memory write for that descriptor.
- R7: With neither control bit 25 nor control bit 24 set, the next descriptor is at the current address plus 16, and the link word has no effect.
- R8: With control bit 25 (end of ring) set, the next descriptor is at csr_ring_base. This holds even when bit 24 is also set.
- R9: With control bit 24 (chain) set and bit 25 clear, the next descriptor address is the link word (word 3).
- R10: With transmit disabled, the engine goes idle once any descriptor in progress is finished. While idle it ignores poll demands and makes no memory access, and re-enabling restarts at the current csr_ring_base.
- R11: tx_irq is a one-cycle pulse in the cycle the status write-back is accepted.
- R12: A memory request keeps its address, direction and write data steady until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_ring_base | input | AW | Byte address of the first descriptor in the ring |
| csr_poll | input | 1 | Poll-demand strobe |
| csr_tx_en | input | 1 | Transmit enable |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access accepted |
| snd_req | output | 1 | Buffer offered to the sender |
| snd_buf_addr | output | AW | Buffer address |
| snd_len | output | LEN_W | Buffer byte count |
| snd_first | output | 1 | First segment of a frame |
| snd_last | output | 1 | Last segment of a frame |
| snd_done | input | 1 | Sender finished with the buffer |
| snd_err | input | 1 | Transmission failed, valid with snd_done |
| tx_irq | output | 1 | Descriptor completion pulse |
| tx_suspended | output | 1 | Engine waits for a poll demand |

## Verification
The hardest situation to reach is a ring that wraps around onto a descriptor the engine has already given back, followed by a poll demand that finds that descriptor owned again. The bench lets each ring run until it wraps and suspends. It then polls once while ownership is still clear, sets ownership through its memory model, waits to show that nothing moves without a poll, and finally polls again. Ring size, memory and sender stalls, and error patterns are swept. Decoy descriptors placed at the sequential addresses reveal any wrong branch in chained rings.

// File: rtl/txr_pkg.sv
package txr_pkg;
    // Descriptor bit positions; the host software depends on these.
    localparam int OWN_BIT    = 31;
    localparam int ERR_BIT    = 15;
    localparam int LAST_BIT   = 30;
    localparam int FIRST_BIT  = 29;
    localparam int EOR_BIT    = 25;
    localparam int CHAIN_BIT  = 24;
    localparam int WORD_BYTES = 4;
    localparam int DATA_W     = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_RD_CTRL,
        ST_RD_BUF,
        ST_RD_LINK,
        ST_SEND,
        ST_WB,
        ST_SUSP
    } txr_state_e;
endpackage

// File: rtl/txr_ctrl_decode.sv
module txr_ctrl_decode
    import txr_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic [DATA_W-1:0] ctrl_word,
    output logic [LEN_W-1:0]  byte_cnt,
    output logic              first_seg,
    output logic              last_seg,
    output logic              ring_end,
    output logic              chained
);
    assign byte_cnt  = ctrl_word[LEN_W-1:0];
    assign first_seg = ctrl_word[FIRST_BIT];
    assign last_seg  = ctrl_word[LAST_BIT];
    assign ring_end  = ctrl_word[EOR_BIT];
    assign chained   = ctrl_word[CHAIN_BIT];

    logic unused_ctrl;
    assign unused_ctrl = ^{ctrl_word[31], ctrl_word[28:26], ctrl_word[23:LEN_W]};
endmodule

// File: rtl/txr_next_addr.sv
module txr_next_addr #(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 16,
    parameter bit CHAIN_EN   = 1'b1
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [AW-1:0] ring_base,
    input  logic [AW-1:0] link_addr,
    input  logic          ring_end,
    input  logic          chained,
    output logic [AW-1:0] next_addr
);
    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

    generate
        if (CHAIN_EN) begin : g_chain
            // End of ring wins over chaining.
            assign next_addr = ring_end ? ring_base :
                               chained  ? link_addr : cur_addr + STEP;
        end else begin : g_linear
            assign next_addr = ring_end ? ring_base : cur_addr + STEP;
            logic unused_link;
            assign unused_link = ^{link_addr, chained};
        end
    endgenerate
endmodule

// File: rtl/txring_engine.sv
module txring_engine
    import txr_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LEN_W      = 11,
    parameter int DESC_BYTES = 16,
    parameter bit CHAIN_EN   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     csr_ring_base,
    input  logic              csr_poll,
    input  logic              csr_tx_en,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              snd_req,
    output logic [AW-1:0]     snd_buf_addr,
    output logic [LEN_W-1:0]  snd_len,
    output logic              snd_first,
    output logic              snd_last,
    input  logic              snd_done,
    input  logic              snd_err,
    output logic              tx_irq,
    output logic              tx_suspended
);
    localparam logic [AW-1:0] OFS_CTRL = AW'(1 * WORD_BYTES);
    localparam logic [AW-1:0] OFS_BUF  = AW'(2 * WORD_BYTES);
    localparam logic [AW-1:0] OFS_LINK = AW'(3 * WORD_BYTES);

    typedef struct packed {
        txr_state_e       st;
        logic [AW-1:0]     cur;
        logic [DATA_W-1:0] ctrl;
        logic [AW-1:0]     bufp;
        logic [AW-1:0]     link;
        logic              err;
    } eng_t;

    eng_t q, d;

    logic          ring_end, chained;
    logic [AW-1:0] nxt_addr;

    txr_ctrl_decode #(.LEN_W(LEN_W)) i_decode (
        .ctrl_word (q.ctrl),
        .byte_cnt  (snd_len),
        .first_seg (snd_first),
        .last_seg  (snd_last),
        .ring_end  (ring_end),
        .chained   (chained)
    );

    txr_next_addr #(.AW(AW), .DESC_BYTES(DESC_BYTES), .CHAIN_EN(CHAIN_EN)) i_next (
        .cur_addr  (q.cur),
        .ring_base (csr_ring_base),
        .link_addr (q.link),
        .ring_end  (ring_end),
        .chained   (chained),
        .next_addr (nxt_addr)
    );

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.cur;
        mem_wdata = '0;
        snd_req   = 1'b0;
        tx_irq    = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.cur = csr_ring_base;
                if (csr_tx_en) d.st = ST_RD_STAT;
            end
            ST_RD_STAT: begin
                mem_req = 1'b1;
                if (mem_ack) d.st = mem_rdata[OWN_BIT] ? ST_RD_CTRL : ST_SUSP;
            end
            ST_RD_CTRL: begin
                mem_req  = 1'b1;
                mem_addr = q.cur + OFS_CTRL;
                if (mem_ack) begin
                    d.ctrl = mem_rdata;
                    d.st   = ST_RD_BUF;
                end
            end
            ST_RD_BUF: begin
                mem_req  = 1'b1;
                mem_addr = q.cur + OFS_BUF;
                if (mem_ack) begin
                    d.bufp = AW'(mem_rdata);
                    d.st   = ST_RD_LINK;
                end
            end
            ST_RD_LINK: begin
                mem_req  = 1'b1;
                mem_addr = q.cur + OFS_LINK;
                if (mem_ack) begin
                    d.link = AW'(mem_rdata);
                    d.st   = ST_SEND;
                end
            end
            ST_SEND: begin
                snd_req = 1'b1;
                if (snd_done) begin
                    d.err = snd_err;
                    d.st  = ST_WB;
                end
            end
            ST_WB: begin
                mem_req            = 1'b1;
                mem_we             = 1'b1;
                mem_wdata[ERR_BIT] = q.err;
                if (mem_ack) begin
                    tx_irq = 1'b1;
                    d.cur  = nxt_addr;
                    d.st   = csr_tx_en ? ST_RD_STAT : ST_IDLE;
                end
            end
            ST_SUSP: begin
                if (!csr_tx_en)    d.st = ST_IDLE;
                else if (csr_poll) d.st = ST_RD_STAT;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign snd_buf_addr = q.bufp;
    assign tx_suspended = (q.st == ST_SUSP);
endmodule

// File: rtl/txr_checker.sv
module txr_checker #(
    parameter int AW    = 32,
    parameter int LEN_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             csr_tx_en,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic [AW-1:0]    mem_addr,
    input logic [31:0]      mem_wdata,
    input logic             snd_req,
    input logic             snd_done,
    input logic [AW-1:0]    snd_buf_addr,
    input logic [LEN_W-1:0] snd_len,
    input logic             tx_irq,
    input logic             tx_suspended
);
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R12
    AST_SEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        snd_req && !snd_done |=> snd_req && $stable(snd_buf_addr) && $stable(snd_len)); // R5
    AST_SEND_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        snd_req |-> !mem_req); // R5
    AST_WB_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> (mem_wdata & ~32'h0000_8000) == 32'h0); // R6
    AST_WB_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        snd_req && snd_done |=> mem_req && mem_we); // R6
    AST_IRQ_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> mem_req && mem_we && mem_ack); // R11
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq); // R11
    AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_suspended |-> !mem_req && !snd_req); // R3
    AST_DISABLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_suspended && !csr_tx_en |=> !tx_suspended && !mem_req); // R10
endmodule

bind txring_engine txr_checker #(.AW(AW), .LEN_W(LEN_W)) i_txr_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .csr_tx_en    (csr_tx_en),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_ack      (mem_ack),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .snd_req      (snd_req),
    .snd_done     (snd_done),
    .snd_buf_addr (snd_buf_addr),
    .snd_len      (snd_len),
    .tx_irq       (tx_irq),
    .tx_suspended (tx_suspended)
);

// File: tb/test_txring_engine.sv
`timescale 1ns/1ps
module test_txring_engine;
    localparam int AW = 32;
    localparam int LW = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [AW-1:0] csr_ring_base = '0;
    logic          csr_poll = 1'b0, csr_tx_en = 1'b0;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic          snd_req, snd_first, snd_last, snd_err;
    logic          snd_done = 1'b0;
    logic [AW-1:0] snd_buf_addr;
    logic [LW-1:0] snd_len;
    logic          tx_irq, tx_suspended;

    txring_engine i_txring_engine (
        .clk(clk), .rst_n(rst_n), .csr_ring_base(csr_ring_base), .csr_poll(csr_poll),
        .csr_tx_en(csr_tx_en), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .snd_req(snd_req), .snd_buf_addr(snd_buf_addr), .snd_len(snd_len),
        .snd_first(snd_first), .snd_last(snd_last), .snd_done(snd_done), .snd_err(snd_err),
        .tx_irq(tx_irq), .tx_suspended(tx_suspended)
    );

    // Behavioural memory: 64 words, byte addresses below 256.
    logic [31:0] mem [0:63];
    logic        tb_clr = 1'b0, tb_we = 1'b0;
    logic [5:0]  tb_idx = '0;
    logic [31:0] tb_wd = '0;
    logic        stall_mode = 1'b0, err_sel = 1'b0, tog = 1'b0;

    assign mem_ack   = mem_req && (!stall_mode || tog);
    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk) begin
        tog <= ~tog;
        if (tb_clr) for (int i = 0; i < 64; i++) mem[i] <= 32'h0;
        else if (tb_we) mem[tb_idx] <= tb_wd;
        else if (mem_req && mem_we && mem_ack) mem[mem_addr[7:2]] <= mem_wdata;
    end

    // Observation log.
    logic          log_clr = 1'b0;
    int            log_cnt = 0, wr_cnt = 0, irq_cnt = 0, rd_cnt = 0;
    logic [AW-1:0] first_rd = '0, last_rd = '0;
    logic          first_seen = 1'b0;
    logic [AW-1:0] log_buf [0:15];
    logic [LW-1:0] log_len [0:15];
    logic          log_f [0:15];
    logic          log_l [0:15];

    assign snd_err = err_sel && log_cnt[0];

    always @(posedge clk) begin
        if (log_clr) begin
            log_cnt <= 0; wr_cnt <= 0; irq_cnt <= 0; rd_cnt <= 0; first_seen <= 1'b0;
        end else begin
            if (snd_req && snd_done) begin
                log_buf[log_cnt[3:0]] <= snd_buf_addr;
                log_len[log_cnt[3:0]] <= snd_len;
                log_f[log_cnt[3:0]]   <= snd_first;
                log_l[log_cnt[3:0]]   <= snd_last;
                log_cnt <= log_cnt + 1;
            end
            if (mem_req && mem_ack && mem_we) wr_cnt <= wr_cnt + 1;
            if (tx_irq) irq_cnt <= irq_cnt + 1;
            if (mem_req && mem_ack && !mem_we) begin
                rd_cnt  <= rd_cnt + 1;
                last_rd <= mem_addr;
                if (!first_seen) begin
                    first_rd   <= mem_addr;
                    first_seen <= 1'b1;
                end
            end
        end
    end

    // Stub sender: finishes after a delay that depends on the stall mode.
    int dly = 0;
    always @(posedge clk) begin
        if (!snd_req || snd_done) begin
            snd_done <= 1'b0;
            dly      <= 0;
        end else if (dly >= (stall_mode ? 3 : 0)) snd_done <= 1'b1;
        else dly <= dly + 1;
    end

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic poke(input logic [AW-1:0] addr, input logic [31:0] data);
        tb_idx = addr[7:2]; tb_wd = data; tb_we = 1'b1;
        tick();
        tb_we = 1'b0;
    endtask

    task automatic clear_all();
        tb_clr = 1'b1; log_clr = 1'b1;
        tick();
        tb_clr = 1'b0; log_clr = 1'b0;
    endtask

    task automatic pulse_poll();
        csr_poll = 1'b1;
        tick();
        csr_poll = 1'b0;
    endtask

    task automatic wait_susp(input string req);
        int n = 0;
        while (!tx_suspended && n < 3000) begin
            tick();
            n++;
        end
        chk(tx_suspended, req, {31'b0, tx_suspended}, 32'h1);
    endtask

    logic [AW-1:0] exp_buf [0:3];
    logic [LW-1:0] exp_len [0:3];
    logic          exp_f [0:3];
    logic          exp_l [0:3];

    task automatic run_ring(input int n, input bit stall, input bit errsel);
        logic [AW-1:0] base = 32'h40;
        csr_tx_en = 1'b0;
        repeat (3) tick();
        clear_all();
        csr_ring_base = base;
        for (int k = 0; k < n; k++) begin
            logic [31:0] w1;
            exp_len[k] = LW'(k * 397 + n * 53 + 1);
            if (n == 4 && k == 3) exp_len[k] = 11'h7FF;
            exp_f[k]   = (k == 0);
            exp_l[k]   = (k == n - 1);
            exp_buf[k] = 32'h1000 * (k + 1) + n;
            w1 = {1'b0, exp_l[k], exp_f[k], 3'b0, (k == n - 1), 1'b0, 13'b0, exp_len[k]};
            if (k[0]) w1 = w1 | 32'h0007_F800;
            poke(base + 16 * k,      32'h8000_0000 | k);
            poke(base + 16 * k + 4,  w1);
            poke(base + 16 * k + 8,  exp_buf[k]);
            poke(base + 16 * k + 12, 32'hDEAD_0000 | k);
        end
        stall_mode = stall; err_sel = errsel;
        csr_tx_en = 1'b1;
        wait_susp("R3");
        chk(first_rd == base, "R2", first_rd, base);
        chk(log_cnt == n, "R5", log_cnt, n);
        for (int k = 0; k < n; k++) begin
            logic [31:0] ew;
            chk(log_buf[k] == exp_buf[k], "R7", log_buf[k], exp_buf[k]);
            chk(log_len[k] == exp_len[k], "R5", 32'(log_len[k]), 32'(exp_len[k]));
            chk(log_f[k] == exp_f[k] && log_l[k] == exp_l[k], "R5",
                {30'b0, log_f[k], log_l[k]}, {30'b0, exp_f[k], exp_l[k]});
            ew = (errsel && k[0]) ? 32'h0000_8000 : 32'h0;
            chk(mem[(base + 16 * k) >> 2] == ew, "R6", mem[(base + 16 * k) >> 2], ew);
        end
        chk(wr_cnt == n, "R6", wr_cnt, n);
        chk(irq_cnt == n, "R11", irq_cnt, n);
        chk(last_rd == base, "R8", last_rd, base);
        chk(rd_cnt == 4 * n + 1, stall ? "R12" : "R7", rd_cnt, 4 * n + 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int r0;
        repeat (3) tick();
        chk(!mem_req && !snd_req && !tx_irq && !tx_suspended, "R1",
            {28'b0, mem_req, snd_req, tx_irq, tx_suspended}, 32'h0);
        rst_n = 1'b1;
        repeat (4) tick();
        chk(!mem_req && !snd_req && !tx_irq && !tx_suspended, "R1",
            {28'b0, mem_req, snd_req, tx_irq, tx_suspended}, 32'h0);

        // Sweep ring size, stalls and error pattern.
        for (int n = 1; n <= 4; n++)
            for (int s = 0; s < 2; s++)
                for (int e = 0; e < 2; e++)
                    run_ring(n, s[0], e[0]);

        // Suspended at base after wrap; descriptor 0 no longer owned.
        r0 = rd_cnt;
        pulse_poll();
        repeat (10) tick();
        chk(rd_cnt == r0 + 1, "R4", rd_cnt, r0 + 1);
        chk(tx_suspended && log_cnt == 4, "R3", log_cnt, 4);
        poke(32'h40, 32'h8000_0000);
        repeat (20) tick();
        chk(log_cnt == 4 && rd_cnt == r0 + 1, "R3", rd_cnt, r0 + 1);
        pulse_poll();
        wait_susp("R4");
        chk(log_cnt == 5, "R4", log_cnt, 5);
        chk(log_buf[4] == exp_buf[0], "R4", log_buf[4], exp_buf[0]);
        chk(last_rd == 32'h50, "R4", last_rd, 32'h50);

        // Chained ring with decoys at sequential addresses.
        csr_tx_en = 1'b0;
        stall_mode = 1'b0; err_sel = 1'b0;
        repeat (3) tick();
        clear_all();
        csr_ring_base = 32'h0;
        poke(32'h00, 32'h8000_0000); poke(32'h04, 32'h2100_003C);
        poke(32'h08, 32'h2000);      poke(32'h0C, 32'h80);
        poke(32'h80, 32'h8000_0000); poke(32'h84, 32'h0100_003D);
        poke(32'h88, 32'h2100);      poke(32'h8C, 32'h30);
        poke(32'h30, 32'h8000_0000); poke(32'h34, 32'h4300_003E);
        poke(32'h38, 32'h2200);      poke(32'h3C, 32'hA0);
        poke(32'h10, 32'h8000_0000); poke(32'h18, 32'h9999);
        poke(32'hA0, 32'h8000_0000); poke(32'hA8, 32'h7777);
        csr_tx_en = 1'b1;
        wait_susp("R9");
        chk(log_cnt == 3, "R9", log_cnt, 3);
        chk(log_buf[0] == 32'h2000 && log_buf[1] == 32'h2100, "R9", log_buf[1], 32'h2100);
        chk(log_buf[2] == 32'h2200, "R9", log_buf[2], 32'h2200);
        chk(log_len[2] == 11'h3E && log_l[2], "R5", 32'(log_len[2]), 32'h3E);
        chk(last_rd == 32'h0, "R8", last_rd, 32'h0);

        // Disable: idle, poll ignored, restart at new base.
        csr_tx_en = 1'b0;
        repeat (3) tick();
        r0 = rd_cnt;
        pulse_poll();
        repeat (10) tick();
        chk(rd_cnt == r0 && !tx_suspended, "R10", rd_cnt, r0);
        clear_all();
        csr_ring_base = 32'hC0;
        poke(32'hC0, 32'h8000_0000); poke(32'hC4, 32'h0200_0007);
        poke(32'hC8, 32'h3000);
        csr_tx_en = 1'b1;
        wait_susp("R10");
        chk(first_rd == 32'hC0, "R10", first_rd, 32'hC0);
        chk(log_cnt == 1 && log_buf[0] == 32'h3000, "R10", log_buf[0], 32'h3000);
        chk(last_rd == 32'hC0, "R8", last_rd, 32'hC0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule